// File: doc/BRIEF.md
# Packed Fixed-Point Precision Converter

This unit widens and narrows packed fixed-point data between three formats: unsigned bytes, signed Q15 halfwords and signed Q31 words. Widening picks two bytes out of a 32-bit source and turns them into two 16-bit halves. The halves can be plain zero-extended integers or Q15 fractions. Widening can also turn one Q15 half into a Q31 word. Narrowing packs two Q31 words into a pair of Q15 halves, or packs two halfword pairs into four bytes. Each narrowing has a plain truncating form and a form that rounds and saturates. The saturating forms report when they had to clamp.

Each operation arrives as one item made of an opcode and two 32-bit operands, `rs` and `rt`. It is carried over a valid/ready handshake. The result comes out one cycle later over a second valid/ready handshake. The input side accepts an item when the output register is empty, or when that register is being drained in the same cycle. While the consumer holds `out_ready` low, the pending result stays frozen, and the input side stalls once it is full.

Top module: `prec_conv_unit`

## Requirements
- R1: Opcodes 0 to 3 zero-extend two bytes of `rt`. Each byte goes to the low 8 bits of a half, and the upper 8 bits of that half are zero. The byte pairs (upper half, lower half) are: op 0 takes bytes 3 and 2, op 1 takes bytes 3 and 1, op 2 takes bytes 1 and 0, op 3 takes bytes 2 and 0. Byte 0 is `rt[7:0]`.
- R2: Opcodes 4 to 7 use the same byte pairs as opcodes 0 to 3. Each chosen byte b becomes the Q15 half {1'b0, b, 7'b0}.
- R3: Opcode 8 gives `{rt[31:16], 16'h0}` and opcode 9 gives `{rt[15:0], 16'h0}`.
- R4: Opcode 10 gives `{rs[31:16], rt[31:16]}`.
- R5: Opcode 11 produces two halves, one from `rs` (upper half of the result) and one from `rt` (lower half). For each word w, the half is bits 31:16 of w + 0x8000. If w is 0x7FFF8000 or greater as a signed value, the half is 0x7FFF instead and the overflow flag is set.
- R6: Opcode 12 gives `{rs[31:24], rs[15:8], rt[31:24], rt[15:8]}`.
- R7: Opcode 13 converts the same four halves, in the same order as opcode 12, using these rules for each half h:
  - a negative h gives 0x00 and sets the overflow flag;
  - h of 0x7FC0 or more gives 0xFF and sets the overflow flag;
  - any other h gives (h + 0x40) >> 7.
- R8: The overflow flag is 0 for every opcode other than 11 and 13. Opcodes 14 and 15 give a result of 0.
- R9: `in_ready` is high whenever the output register is empty or `out_ready` is high. Each accepted item yields exactly one result, in order, with `out_valid` high on the cycle after acceptance.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_rd` and `out_ovf` hold their values.
- R11: During and after reset, `out_valid`, `out_rd` and `out_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Unit can take an item this cycle |
| in_op | input | 4 | Operation code |
| in_rs | input | 32 | First operand |
| in_rt | input | 32 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_rd | output | 32 | Converted result |
| out_ovf | output | 1 | A saturating narrowing clamped |

## Verification
Two things can happen in the same cycle: a new item is accepted while the held result is drained. The bench provokes this by streaming items back to back with `out_ready` high, and then with `out_ready` toggling at random. The scoreboard queue checks that no result is dropped, duplicated or reordered when a load and a drain fall on the same edge. The stalled cycles in between are judged by comparing the held output against its value in the previous cycle.

// File: rtl/prec_pkg.sv
`timescale 1ns/1ps
package prec_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = WORD_W / 4;
  localparam int OP_W   = 4;
  localparam int N_BYTE = WORD_W / BYTE_W;

  typedef enum logic [OP_W-1:0] {
    OP_ZX_L   = 4'd0,
    OP_ZX_LA  = 4'd1,
    OP_ZX_R   = 4'd2,
    OP_ZX_RA  = 4'd3,
    OP_FR_L   = 4'd4,
    OP_FR_LA  = 4'd5,
    OP_FR_R   = 4'd6,
    OP_FR_RA  = 4'd7,
    OP_Q31_HI = 4'd8,
    OP_Q31_LO = 4'd9,
    OP_W2H_T  = 4'd10,
    OP_W2H_R  = 4'd11,
    OP_H2B_T  = 4'd12,
    OP_H2B_S  = 4'd13,
    OP_RSV0   = 4'd14,
    OP_RSV1   = 4'd15
  } prec_op_e;

  typedef struct packed {
    logic              ovf;
    logic [WORD_W-1:0] rd;
  } prec_res_t;
endpackage

// File: rtl/prec_expand.sv
`timescale 1ns/1ps
module prec_expand
  import prec_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] rt,
  output logic [WORD_W-1:0] rd
);
  logic [BYTE_W-1:0] byte_hi, byte_lo;
  logic [HALF_W-1:0] half_hi, half_lo;
  logic              frac_mode;

  // pair pattern from the low two opcode bits
  always_comb begin
    unique case (op[1:0])
      2'd0: begin byte_hi = rt[4*BYTE_W-1:3*BYTE_W]; byte_lo = rt[3*BYTE_W-1:2*BYTE_W]; end
      2'd1: begin byte_hi = rt[4*BYTE_W-1:3*BYTE_W]; byte_lo = rt[2*BYTE_W-1:BYTE_W];   end
      2'd2: begin byte_hi = rt[2*BYTE_W-1:BYTE_W];   byte_lo = rt[BYTE_W-1:0];          end
      default: begin byte_hi = rt[3*BYTE_W-1:2*BYTE_W]; byte_lo = rt[BYTE_W-1:0];       end
    endcase
  end

  assign frac_mode = op[2];

  always_comb begin
    if (frac_mode) begin
      half_hi = {1'b0, byte_hi, {(HALF_W-BYTE_W-1){1'b0}}};
      half_lo = {1'b0, byte_lo, {(HALF_W-BYTE_W-1){1'b0}}};
    end else begin
      half_hi = {{(HALF_W-BYTE_W){1'b0}}, byte_hi};
      half_lo = {{(HALF_W-BYTE_W){1'b0}}, byte_lo};
    end
  end

  always_comb begin
    if (op == OP_Q31_HI)
      rd = {rt[WORD_W-1:HALF_W], {HALF_W{1'b0}}};
    else if (op == OP_Q31_LO)
      rd = {rt[HALF_W-1:0], {HALF_W{1'b0}}};
    else
      rd = {half_hi, half_lo};
  end

  // R1
  always_comb begin
    if (op < 4'd4)
      zx_upper_chk: assert (rd[WORD_W-1:WORD_W-BYTE_W] == '0 && rd[HALF_W-1:BYTE_W] == '0);
  end

  // R2
  always_comb begin
    if (op >= 4'd4 && op < 4'd8)
      frac_sign_chk: assert (!rd[WORD_W-1] && !rd[HALF_W-1] && rd[6:0] == '0);
  end
endmodule

// File: rtl/prec_w2h_lane.sv
`timescale 1ns/1ps
module prec_w2h_lane
  import prec_pkg::*;
(
  input  logic [WORD_W-1:0] w,
  input  logic              rnd_en,
  output logic [HALF_W-1:0] h,
  output logic              sat
);
  localparam logic [WORD_W:0]   RND_K = WORD_W'(1) << (HALF_W-1);
  localparam logic [HALF_W-1:0] H_MAX = {1'b0, {(HALF_W-1){1'b1}}};

  logic [WORD_W:0] sum;

  assign sum = {w[WORD_W-1], w} + RND_K;

  always_comb begin
    sat = rnd_en && !w[WORD_W-1] && sum[WORD_W-1];
    if (!rnd_en)  h = w[WORD_W-1:HALF_W];
    else if (sat) h = H_MAX;
    else          h = sum[WORD_W-1:HALF_W];
  end

  // R5
  always_comb begin
    if (sat) w2h_sat_chk: assert (h == H_MAX && !w[WORD_W-1]);
  end
endmodule

// File: rtl/prec_h2b_lane.sv
`timescale 1ns/1ps
module prec_h2b_lane
  import prec_pkg::*;
(
  input  logic [HALF_W-1:0] h,
  input  logic              sat_en,
  output logic [BYTE_W-1:0] b,
  output logic              clamp
);
  localparam logic [HALF_W-1:0] RND_K = HALF_W'(1) << (HALF_W-BYTE_W-2);

  logic [HALF_W-1:0] sum;

  assign sum = {1'b0, h[HALF_W-2:0]} + RND_K;

  always_comb begin
    if (!sat_en) begin
      b = h[HALF_W-1:HALF_W-BYTE_W];
      clamp = 1'b0;
    end else if (h[HALF_W-1]) begin
      b = '0;
      clamp = 1'b1;
    end else if (sum[HALF_W-1]) begin
      b = '1;
      clamp = 1'b1;
    end else begin
      b = sum[HALF_W-2:HALF_W-BYTE_W-1];
      clamp = 1'b0;
    end
  end

  // R7
  always_comb begin
    if (clamp) h2b_clamp_chk: assert (b == '0 || b == '1);
  end
endmodule

// File: rtl/prec_reduce.sv
`timescale 1ns/1ps
module prec_reduce
  import prec_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] rs,
  input  logic [WORD_W-1:0] rt,
  output logic [WORD_W-1:0] rd,
  output logic              ovf
);
  logic [HALF_W-1:0] w2h_h   [2];
  logic [1:0]        w2h_sat;
  logic [BYTE_W-1:0] h2b_b   [N_BYTE];
  logic [N_BYTE-1:0] h2b_clp;
  logic [WORD_W-1:0] words   [2];
  logic [HALF_W-1:0] halves  [N_BYTE];

  assign words[0]  = rs;
  assign words[1]  = rt;
  assign halves[0] = rs[WORD_W-1:HALF_W];
  assign halves[1] = rs[HALF_W-1:0];
  assign halves[2] = rt[WORD_W-1:HALF_W];
  assign halves[3] = rt[HALF_W-1:0];

  for (genvar i = 0; i < 2; i++) begin : g_w2h
    prec_w2h_lane u_lane (
      .w(words[i]), .rnd_en(op == OP_W2H_R), .h(w2h_h[i]), .sat(w2h_sat[i])
    );
  end

  for (genvar j = 0; j < N_BYTE; j++) begin : g_h2b
    prec_h2b_lane u_lane (
      .h(halves[j]), .sat_en(op == OP_H2B_S), .b(h2b_b[j]), .clamp(h2b_clp[j])
    );
  end

  always_comb begin
    rd  = '0;
    ovf = 1'b0;
    unique case (op)
      OP_W2H_T, OP_W2H_R: begin
        rd  = {w2h_h[0], w2h_h[1]};
        ovf = |w2h_sat;
      end
      OP_H2B_T, OP_H2B_S: begin
        rd  = {h2b_b[0], h2b_b[1], h2b_b[2], h2b_b[3]};
        ovf = |h2b_clp;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/prec_conv_unit.sv
`timescale 1ns/1ps
module prec_conv_unit
  import prec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WORD_W-1:0] in_rs,
  input  logic [WORD_W-1:0] in_rt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_rd,
  output logic              out_ovf
);
  logic [WORD_W-1:0] exp_rd, red_rd;
  logic              red_ovf;
  prec_res_t         nxt, held;
  logic              take;

  prec_expand u_expand (.op(in_op), .rt(in_rt), .rd(exp_rd));

  prec_reduce u_reduce (
    .op(in_op), .rs(in_rs), .rt(in_rt), .rd(red_rd), .ovf(red_ovf)
  );

  always_comb begin
    if (in_op < OP_W2H_T) nxt = '{ovf: 1'b0, rd: exp_rd};
    else                  nxt = '{ovf: red_ovf, rd: red_rd};
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      held      <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_rd  = held.rd;
  assign out_ovf = held.ovf;

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rd) && $stable(out_ovf));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op != OP_W2H_R && in_op != OP_H2B_S |=> !out_ovf);
endmodule

// File: tb/test_prec_conv_unit.sv
`timescale 1ns/1ps
module test_prec_conv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_rs = '0, in_rt = '0;
  logic        out_valid, out_ready = 1'b1, out_ovf;
  logic [31:0] out_rd;

  int n_chk = 0, n_fail = 0;
  bit rnd_ready = 1'b0;
  bit done = 1'b0;

  typedef struct {logic [3:0] op; logic [32:0] exp;} item_t;
  item_t q[$];

  always #5 clk = ~clk;

  prec_conv_unit i_prec_conv_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rs(in_rs), .in_rt(in_rt), .out_valid(out_valid),
    .out_ready(out_ready), .out_rd(out_rd), .out_ovf(out_ovf)
  );

  function automatic string req_of(input logic [3:0] op);
    if (op < 4)   return "R1";
    if (op < 8)   return "R2";
    if (op < 10)  return "R3";
    if (op == 10) return "R4";
    if (op == 11) return "R5";
    if (op == 12) return "R6";
    if (op == 13) return "R7";
    return "R8";
  endfunction

  function automatic logic [7:0] pick(input logic [31:0] v, input int k);
    return 8'((v >> (8 * k)) & 32'hFF);
  endfunction

  function automatic logic [16:0] w2h_round(input logic [31:0] w);
    longint v;
    v = longint'($signed(w)) + 32768;
    if (v > 64'sd2147483647) return {1'b1, 16'h7FFF};
    return {1'b0, 16'((v >>> 16) & 16'hFFFF)};
  endfunction

  function automatic logic [8:0] h2b_sat(input logic [15:0] h);
    int v;
    if ($signed(h) < 0) return {1'b1, 8'h00};
    v = (int'(h) + 64) / 128;
    if (v > 255) return {1'b1, 8'hFF};
    return {1'b0, 8'(v)};
  endfunction

  // expected {ovf, rd} from the requirements
  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] rs,
                                        input logic [31:0] rt);
    int hi_k, lo_k;
    logic [16:0] a, b;
    logic [8:0] c0, c1, c2, c3;
    case (op[1:0])
      2'd0: begin hi_k = 3; lo_k = 2; end
      2'd1: begin hi_k = 3; lo_k = 1; end
      2'd2: begin hi_k = 1; lo_k = 0; end
      default: begin hi_k = 2; lo_k = 0; end
    endcase
    if (op < 4)
      return {1'b0, 8'h00, pick(rt, hi_k), 8'h00, pick(rt, lo_k)};
    if (op < 8)
      return {1'b0, 1'b0, pick(rt, hi_k), 7'h00, 1'b0, pick(rt, lo_k), 7'h00};
    if (op == 8)  return {1'b0, rt[31:16], 16'h0};
    if (op == 9)  return {1'b0, rt[15:0], 16'h0};
    if (op == 10) return {1'b0, rs[31:16], rt[31:16]};
    if (op == 11) begin
      a = w2h_round(rs); b = w2h_round(rt);
      return {a[16] | b[16], a[15:0], b[15:0]};
    end
    if (op == 12) return {1'b0, pick(rs, 3), pick(rs, 1), pick(rt, 3), pick(rt, 1)};
    if (op == 13) begin
      c0 = h2b_sat(rs[31:16]); c1 = h2b_sat(rs[15:0]);
      c2 = h2b_sat(rt[31:16]); c3 = h2b_sat(rt[15:0]);
      return {c0[8] | c1[8] | c2[8] | c3[8], c0[7:0], c1[7:0], c2[7:0], c3[7:0]};
    end
    return 33'h0;
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual ovf=%0b rd=%h, expected ovf=%0b rd=%h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // driver: pushes expected item at the negedge before the accepting edge
  task automatic send(input logic [3:0] op, input logic [31:0] rs, input logic [31:0] rt);
    bit acc;
    in_valid = 1'b1; in_op = op; in_rs = rs; in_rt = rt;
    do begin
      @(negedge clk);
      acc = in_ready;
      if (acc) q.push_back('{op: op, exp: model(op, rs, rt)});
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  // ready pattern
  always @(posedge clk) begin
    #1;
    if (rnd_ready) out_ready = ($urandom % 3) != 0;
    else           out_ready = 1'b1;
  end

  // monitor: scoreboard compare, and hold check while stalled
  logic        was_stalled = 1'b0;
  logic [32:0] stall_val = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled) begin
        check("R10", {!out_valid, out_ovf, out_rd} == {1'b0, stall_val} ? {out_ovf, out_rd}
              : {~stall_val[32], stall_val[31:0]}, stall_val);
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) check("R9", {out_ovf, out_rd}, 33'h1_DEAD_BEEF);
        else begin
          item_t it;
          it = q.pop_front();
          check(req_of(it.op), {out_ovf, out_rd}, it.exp);
        end
      end
      was_stalled = out_valid && !out_ready;
      stall_val   = {out_ovf, out_rd};
    end
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11
    check("R11", {out_valid, out_ovf, out_rd} == 34'h0 ? 33'h0 : 33'h1, 33'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check("R11", {out_ovf, out_rd}, 33'h0);
    // R9: empty register means ready
    check("R9", {32'h0, in_ready}, 33'h1);
    @(posedge clk); #1;

    // R1 / R2 selections
    for (int o = 0; o < 8; o++) send(4'(o), 32'h0, 32'hA1B2C3D4);
    send(4'd4, 32'h0, 32'hFF00FF00);
    // R3
    send(4'd8, 32'h0, 32'h8001_7FFE);
    send(4'd9, 32'h0, 32'h8001_7FFE);
    // R4
    send(4'd10, 32'h12345678, 32'h9ABCDEF0);
    // R5 corners
    send(4'd11, 32'h7FFF8000, 32'h7FFF7FFF);
    send(4'd11, 32'h80000000, 32'hFFFF7FFF);
    send(4'd11, 32'h7FFFFFFF, 32'h00018000);
    // R6
    send(4'd12, 32'h8142C3E4, 32'h0F1E2D3C);
    // R7 corners
    send(4'd13, 32'h8000_7FC0, 32'h7FBF_0040);
    send(4'd13, 32'h0000_003F, 32'hFFFF_4000);
    send(4'd13, 32'h7FFF_0000, 32'h0080_00BF);
    // R8 reserved and no flag on truncating forms
    send(4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF);
    send(4'd15, 32'h7FFF8000, 32'h80000000);
    send(4'd12, 32'h80008000, 32'h7FFF7FFF);
    send(4'd10, 32'h7FFF8000, 32'h7FFF8000);

    // R9 / R10: random back-pressure and back-to-back loads
    rnd_ready = 1'b1;
    for (int i = 0; i < 400; i++) send(4'($urandom), $urandom, $urandom);
    for (int i = 0; i < 50; i++)
      send(4'(11 + 2 * ($urandom % 2)), 32'h7FFF0000 | ($urandom & 32'hFFFF),
           $urandom);
    rnd_ready = 1'b0;

    for (int k = 0; k < 20 && q.size() != 0; k++) @(posedge clk);
    check("R9", {1'b0, 32'(q.size())}, 33'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule